// File: doc/BRIEF.md
# Pipeline Hazard and Operand Forwarding Control

This block is the combinational hazard controller for a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). It looks at the source registers of the instruction now in execute, and at the store-data source of the instruction now in memory. It compares them with the destination registers of the older instructions still in flight. From these comparisons it drives the operand-forward mux selects and the store-data forward select.

It also drives the enable and bubble-insert (flush) control of every pipeline register. The register file is transparent: a same-cycle write and read of one register returns the new value. For that reason no bypass from writeback into decode is produced here.

Control runs in one of four modes, picked each cycle by priority:
- `CTL_FREEZE`: a cache has not yet given its response.
- `CTL_FLUSH`: a branch or jump resolved taken in the memory stage. Static not-taken prediction means the three younger instructions are on the wrong path.
- `CTL_LOAD_HOLD`: a load in memory feeds an operand in execute.
- `CTL_RUN`: none of the above.

The mode moves freely between any two of the four on every cycle, since it is recomputed from the current inputs alone. The block also gives one-cycle event pulses for the performance counters.

Top module: `hz_unit`

## Requirements
- R1: When a used, nonzero execute source matches the memory-stage destination, that destination is written, and the memory-stage instruction is not a load, the operand select is 1 (memory-stage result).
- R2: When a used, nonzero execute source has no forwardable memory-stage match but matches a written writeback destination, the operand select is 2 (writeback result). Otherwise the select is 0 (register file).
- R3: When both the memory-stage and writeback-stage destinations match a source, the memory-stage value (select 1) wins.
- R4: `fwd_store_data` is 1 exactly when the memory-stage instruction is a store, its data source is nonzero, and that source matches a written writeback destination.
- R5: A source register equal to x0 (index 0) never causes a forward or a load-use stall.
- R6: A source marked unused never causes a forward or a load-use stall.
- R7: A load-use hazard exists when the memory stage holds a written load whose destination matches a used, nonzero execute source. With no memory wait and no taken branch, it gives:
  - `pc_en`, `ifid_en` and `idex_en` low;
  - `exmem_en` and `exmem_flush` high, inserting a bubble;
  - `memwb_en` high;
  - `perf_load_use` high.
- R8: When `imem_resp` is low, or `dmem_req` is high with `dmem_resp` low, every enable is low, every flush is low, and only `perf_mem_stall` is high.
- R9: When `mem_br_taken` is high with no memory wait, every enable is high, `ifid_flush`, `idex_flush` and `exmem_flush` are high, and `perf_flush` is high.
- R10: Priority: a memory wait overrides a taken branch, and a taken branch overrides a load-use hazard.
- R11: With no hazard, every enable is high, every flush is low, and all three performance pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs1 | input | AW | First source index of the execute-stage instruction |
| ex_rs2 | input | AW | Second source index of the execute-stage instruction |
| ex_rs1_used | input | 1 | Execute instruction reads its first source |
| ex_rs2_used | input | 1 | Execute instruction reads its second source |
| mem_rd | input | AW | Destination index of the memory-stage instruction |
| mem_rd_we | input | 1 | Memory-stage instruction writes a register |
| mem_is_load | input | 1 | Memory-stage instruction is a load |
| mem_rs2 | input | AW | Store-data source index of the memory-stage instruction |
| mem_is_store | input | 1 | Memory-stage instruction is a store |
| wb_rd | input | AW | Destination index of the writeback-stage instruction |
| wb_rd_we | input | 1 | Writeback-stage instruction writes a register |
| mem_br_taken | input | 1 | Control transfer in memory stage resolved taken |
| imem_resp | input | 1 | Instruction cache response present |
| dmem_req | input | 1 | Data cache access in progress |
| dmem_resp | input | 1 | Data cache response present |
| fwd_a | output | 2 | First operand select: 0 register file, 1 memory stage, 2 writeback |
| fwd_b | output | 2 | Second operand select, same encoding |
| fwd_store_data | output | 1 | Store data taken from writeback result |
| pc_en | output | 1 | Program counter update enable |
| ifid_en | output | 1 | Fetch/decode register enable |
| idex_en | output | 1 | Decode/execute register enable |
| exmem_en | output | 1 | Execute/memory register enable |
| memwb_en | output | 1 | Memory/writeback register enable |
| ifid_flush | output | 1 | Load bubble into fetch/decode register |
| idex_flush | output | 1 | Load bubble into decode/execute register |
| exmem_flush | output | 1 | Load bubble into execute/memory register |
| perf_load_use | output | 1 | Load-use stall event pulse |
| perf_mem_stall | output | 1 | Memory wait event pulse |
| perf_flush | output | 1 | Wrong-path flush event pulse |

## Verification
The operand selects are swept over every combination of four register indices (including x0) for both sources and both older destinations, crossed with all use, write, and load flags. Each operand therefore meets these cases:
- no match;
- a memory-only match;
- a writeback-only match;
- a double match, which tells apart the priority order;
- a load match, which must stall rather than forward.

The store-data path gets a similar full sweep.

The control modes are tried with every combination of the two cache responses, the data request, the taken branch and a present or absent load-use hazard. This shows that the freeze, flush and hold modes displace each other only in the stated order.

// File: rtl/hz_pkg.sv
package hz_pkg;

    typedef enum logic [1:0] {
        SRC_REGFILE = 2'd0,
        SRC_MEM     = 2'd1,
        SRC_WB      = 2'd2
    } opsrc_e;

    typedef enum logic [1:0] {
        CTL_RUN       = 2'd0,
        CTL_FREEZE    = 2'd1,
        CTL_FLUSH     = 2'd2,
        CTL_LOAD_HOLD = 2'd3
    } ctl_mode_e;

    localparam int unsigned NUM_OPERANDS = 2;

endpackage

// File: rtl/hz_operand_fwd.sv
module hz_operand_fwd
    import hz_pkg::*;
#(
    parameter int unsigned AW = 5
) (
    input  logic [AW-1:0] src,
    input  logic          src_used,
    input  logic [AW-1:0] mem_rd,
    input  logic          mem_rd_we,
    input  logic          mem_is_load,
    input  logic [AW-1:0] wb_rd,
    input  logic          wb_rd_we,
    output opsrc_e        sel,
    output logic          load_hit
);

    logic live;
    logic mem_match;
    logic wb_match;

    always_comb begin
        live      = src_used && (src != '0);
        mem_match = live && mem_rd_we && (mem_rd == src);
        wb_match  = live && wb_rd_we && (wb_rd == src);
        load_hit  = mem_match && mem_is_load;
        if (mem_match && !mem_is_load) begin
            sel = SRC_MEM;
        end else if (wb_match) begin
            sel = SRC_WB;
        end else begin
            sel = SRC_REGFILE;
        end
    end

    always_comb begin
        if (src == '0) begin
            a_r5_x0_no_fwd: assert (sel == SRC_REGFILE && !load_hit)
                else $error("R5: x0 operand forwarded or stalled");
        end
        if (src_used == 1'b0) begin
            a_r6_unused_no_fwd: assert (sel == SRC_REGFILE && !load_hit)
                else $error("R6: unused operand forwarded or stalled");
        end
        if (load_hit == 1'b1) begin
            a_r7_load_not_from_mem: assert (sel != SRC_MEM)
                else $error("R7: load result forwarded from memory stage");
        end
    end

endmodule

// File: rtl/hz_store_fwd.sv
module hz_store_fwd #(
    parameter int unsigned AW = 5
) (
    input  logic [AW-1:0] mem_rs2,
    input  logic          mem_is_store,
    input  logic [AW-1:0] wb_rd,
    input  logic          wb_rd_we,
    output logic          fwd_store
);

    always_comb begin
        fwd_store = mem_is_store && wb_rd_we && (mem_rs2 != '0) && (wb_rd == mem_rs2);
    end

    always_comb begin
        if (mem_rs2 == '0) begin
            a_r4_store_x0: assert (!fwd_store)
                else $error("R4: store data forwarded for x0");
        end
    end

endmodule

// File: rtl/hz_pipe_ctl.sv
module hz_pipe_ctl
    import hz_pkg::*;
(
    input  logic load_hit,
    input  logic br_taken,
    input  logic imem_resp,
    input  logic dmem_req,
    input  logic dmem_resp,
    output logic pc_en,
    output logic ifid_en,
    output logic idex_en,
    output logic exmem_en,
    output logic memwb_en,
    output logic ifid_flush,
    output logic idex_flush,
    output logic exmem_flush,
    output logic perf_load_use,
    output logic perf_mem_stall,
    output logic perf_flush
);

    ctl_mode_e mode;
    logic      mem_wait;

    always_comb begin
        mem_wait = !imem_resp || (dmem_req && !dmem_resp);
        if (mem_wait) begin
            mode = CTL_FREEZE;
        end else if (br_taken) begin
            mode = CTL_FLUSH;
        end else if (load_hit) begin
            mode = CTL_LOAD_HOLD;
        end else begin
            mode = CTL_RUN;
        end
    end

    always_comb begin
        pc_en          = 1'b1;
        ifid_en        = 1'b1;
        idex_en        = 1'b1;
        exmem_en       = 1'b1;
        memwb_en       = 1'b1;
        ifid_flush     = 1'b0;
        idex_flush     = 1'b0;
        exmem_flush    = 1'b0;
        perf_load_use  = 1'b0;
        perf_mem_stall = 1'b0;
        perf_flush     = 1'b0;
        unique case (mode)
            CTL_RUN: begin
            end
            CTL_FREEZE: begin
                pc_en          = 1'b0;
                ifid_en        = 1'b0;
                idex_en        = 1'b0;
                exmem_en       = 1'b0;
                memwb_en       = 1'b0;
                perf_mem_stall = 1'b1;
            end
            CTL_FLUSH: begin
                ifid_flush  = 1'b1;
                idex_flush  = 1'b1;
                exmem_flush = 1'b1;
                perf_flush  = 1'b1;
            end
            CTL_LOAD_HOLD: begin
                pc_en         = 1'b0;
                ifid_en       = 1'b0;
                idex_en       = 1'b0;
                exmem_flush   = 1'b1;
                perf_load_use = 1'b1;
            end
            default: begin
            end
        endcase
    end

    always_comb begin
        if (perf_mem_stall == 1'b1) begin
            a_r8_freeze_all: assert (!pc_en && !ifid_en && !idex_en && !exmem_en && !memwb_en
                                     && !ifid_flush && !idex_flush && !exmem_flush)
                else $error("R8: stage moved or flushed during memory wait");
        end
        if (br_taken == 1'b1 && imem_resp == 1'b1 && !(dmem_req && !dmem_resp)) begin
            a_r10_flush_over_hold: assert (!perf_load_use && ifid_flush)
                else $error("R10: load hold taken over flush");
        end
        if (perf_load_use == 1'b1) begin
            a_r7_hold_bubble: assert (memwb_en && exmem_en && exmem_flush && !idex_en)
                else $error("R7: load hold shape wrong");
        end
        if (mode inside {CTL_RUN, CTL_FREEZE, CTL_FLUSH, CTL_LOAD_HOLD}) begin
            a_r10_one_event: assert ($countones({perf_load_use, perf_mem_stall, perf_flush}) <= 1)
                else $error("R10: more than one event pulse");
        end
    end

endmodule

// File: rtl/hz_unit.sv
module hz_unit
    import hz_pkg::*;
#(
    parameter int unsigned AW = 5
) (
    input  logic [AW-1:0] ex_rs1,
    input  logic [AW-1:0] ex_rs2,
    input  logic          ex_rs1_used,
    input  logic          ex_rs2_used,
    input  logic [AW-1:0] mem_rd,
    input  logic          mem_rd_we,
    input  logic          mem_is_load,
    input  logic [AW-1:0] mem_rs2,
    input  logic          mem_is_store,
    input  logic [AW-1:0] wb_rd,
    input  logic          wb_rd_we,
    input  logic          mem_br_taken,
    input  logic          imem_resp,
    input  logic          dmem_req,
    input  logic          dmem_resp,
    output logic [1:0]    fwd_a,
    output logic [1:0]    fwd_b,
    output logic          fwd_store_data,
    output logic          pc_en,
    output logic          ifid_en,
    output logic          idex_en,
    output logic          exmem_en,
    output logic          memwb_en,
    output logic          ifid_flush,
    output logic          idex_flush,
    output logic          exmem_flush,
    output logic          perf_load_use,
    output logic          perf_mem_stall,
    output logic          perf_flush
);

    logic [AW-1:0] op_src  [NUM_OPERANDS];
    logic          op_used [NUM_OPERANDS];
    opsrc_e        op_sel  [NUM_OPERANDS];
    logic [NUM_OPERANDS-1:0] op_load_hit;

    assign op_src[0]  = ex_rs1;
    assign op_src[1]  = ex_rs2;
    assign op_used[0] = ex_rs1_used;
    assign op_used[1] = ex_rs2_used;

    for (genvar g = 0; g < NUM_OPERANDS; g++) begin : g_operand
        hz_operand_fwd #(.AW(AW)) u_fwd (
            .src         (op_src[g]),
            .src_used    (op_used[g]),
            .mem_rd      (mem_rd),
            .mem_rd_we   (mem_rd_we),
            .mem_is_load (mem_is_load),
            .wb_rd       (wb_rd),
            .wb_rd_we    (wb_rd_we),
            .sel         (op_sel[g]),
            .load_hit    (op_load_hit[g])
        );
    end

    assign fwd_a = op_sel[0];
    assign fwd_b = op_sel[1];

    hz_store_fwd #(.AW(AW)) u_store (
        .mem_rs2      (mem_rs2),
        .mem_is_store (mem_is_store),
        .wb_rd        (wb_rd),
        .wb_rd_we     (wb_rd_we),
        .fwd_store    (fwd_store_data)
    );

    hz_pipe_ctl u_ctl (
        .load_hit       (|op_load_hit),
        .br_taken       (mem_br_taken),
        .imem_resp      (imem_resp),
        .dmem_req       (dmem_req),
        .dmem_resp      (dmem_resp),
        .pc_en          (pc_en),
        .ifid_en        (ifid_en),
        .idex_en        (idex_en),
        .exmem_en       (exmem_en),
        .memwb_en       (memwb_en),
        .ifid_flush     (ifid_flush),
        .idex_flush     (idex_flush),
        .exmem_flush    (exmem_flush),
        .perf_load_use  (perf_load_use),
        .perf_mem_stall (perf_mem_stall),
        .perf_flush     (perf_flush)
    );

    always_comb begin
        if (fwd_a == 2'd1 && fwd_b == 2'd1) begin
            a_r1_same_mem_src: assert (ex_rs1 == ex_rs2)
                else $error("R1: both operands from memory stage with different sources");
        end
    end

endmodule

// File: tb/tb_hz_unit.sv
module tb_hz_unit;

    localparam int AW = 5;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [AW-1:0] ex_rs1, ex_rs2, mem_rd, mem_rs2, wb_rd;
    logic ex_rs1_used, ex_rs2_used, mem_rd_we, mem_is_load, mem_is_store, wb_rd_we;
    logic mem_br_taken, imem_resp, dmem_req, dmem_resp;
    logic [1:0] fwd_a, fwd_b;
    logic fwd_store_data, pc_en, ifid_en, idex_en, exmem_en, memwb_en;
    logic ifid_flush, idex_flush, exmem_flush, perf_load_use, perf_mem_stall, perf_flush;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    hz_unit #(.AW(AW)) dut (.*);

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_sel(input int rs, input bit used, input int mrd, input bit mwe,
                                   input bit mld, input int wrd, input bit wwe);
        if (!used || rs == 0) return 0;
        if (mwe && !mld && mrd == rs) return 1;
        if (wwe && wrd == rs) return 2;
        return 0;
    endfunction

    function automatic bit exp_ld(input int rs, input bit used, input int mrd, input bit mwe,
                                  input bit mld);
        return used && rs != 0 && mwe && mld && mrd == rs;
    endfunction

    // expected control word: {pc,ifid,idex,exmem,memwb,fl_ifid,fl_idex,fl_exmem,p_lu,p_ms,p_fl}
    function automatic int exp_ctl(input bit ld, input bit br, input bit ir, input bit dq, input bit dr);
        if (!ir || (dq && !dr)) return 11'b00000_000_010;
        if (br)                 return 11'b11111_111_001;
        if (ld)                 return 11'b00011_001_100;
        return 11'b11111_000_000;
    endfunction

    function automatic int act_ctl();
        return {pc_en, ifid_en, idex_en, exmem_en, memwb_en, ifid_flush, idex_flush,
                exmem_flush, perf_load_use, perf_mem_stall, perf_flush};
    endfunction

    task automatic idle();
        ex_rs1 = '0; ex_rs2 = '0; ex_rs1_used = 0; ex_rs2_used = 0;
        mem_rd = '0; mem_rd_we = 0; mem_is_load = 0; mem_rs2 = '0; mem_is_store = 0;
        wb_rd = '0; wb_rd_we = 0; mem_br_taken = 0; imem_resp = 1; dmem_req = 0; dmem_resp = 0;
    endtask

    initial begin
        idle();
        @(negedge clk);
        #1;
        chk("R11 quiescent ctl", act_ctl(), 11'b11111_000_000);
        chk("R11 quiescent fwd", {fwd_a, fwd_b, fwd_store_data}, 0);

        // directed: double match, memory wins
        ex_rs1 = 5'd7; ex_rs1_used = 1; mem_rd = 5'd7; mem_rd_we = 1; wb_rd = 5'd7; wb_rd_we = 1;
        @(negedge clk); #1;
        chk("R3 double match", fwd_a, 1);
        mem_rd_we = 0;
        @(negedge clk); #1;
        chk("R2 wb only", fwd_a, 2);
        mem_rd_we = 1; wb_rd_we = 0;
        @(negedge clk); #1;
        chk("R1 mem only", fwd_a, 1);
        idle();

        // sweep operand forwarding and load-use
        for (int f = 0; f < 32; f++) begin
            for (int a = 0; a < 4; a++) begin
                for (int b = 0; b < 4; b++) begin
                    for (int m = 0; m < 4; m++) begin
                        for (int w = 0; w < 4; w++) begin
                            bit u1, u2, mwe, mld, wwe, ld;
                            u1 = f[0]; u2 = f[1]; mwe = f[2]; mld = f[3]; wwe = f[4];
                            @(negedge clk);
                            ex_rs1 = AW'(a); ex_rs2 = AW'(b); ex_rs1_used = u1; ex_rs2_used = u2;
                            mem_rd = AW'(m); mem_rd_we = mwe; mem_is_load = mld;
                            wb_rd = AW'(w); wb_rd_we = wwe;
                            #1;
                            chk("R1 R2 R3 R5 R6 fwd_a", fwd_a, exp_sel(a, u1, m, mwe, mld, w, wwe));
                            chk("R1 R2 R3 R5 R6 fwd_b", fwd_b, exp_sel(b, u2, m, mwe, mld, w, wwe));
                            ld = exp_ld(a, u1, m, mwe, mld) || exp_ld(b, u2, m, mwe, mld);
                            chk("R7 R11 ctl", act_ctl(), exp_ctl(ld, 0, 1, 0, 0));
                        end
                    end
                end
            end
        end
        idle();

        // sweep store data forwarding
        for (int s = 0; s < 4; s++) begin
            for (int w = 0; w < 4; w++) begin
                for (int f = 0; f < 4; f++) begin
                    @(negedge clk);
                    mem_rs2 = AW'(s); mem_is_store = f[0]; wb_rd = AW'(w); wb_rd_we = f[1];
                    #1;
                    chk("R4 R5 fwd_store_data", fwd_store_data,
                        (f[0] && f[1] && s != 0 && s == w) ? 1 : 0);
                end
            end
        end
        idle();

        // sweep control priority
        for (int c = 0; c < 32; c++) begin
            @(negedge clk);
            ex_rs1 = 5'd3; ex_rs1_used = 1; mem_rd_we = 1; mem_is_load = 1;
            mem_rd = c[0] ? 5'd3 : 5'd4;
            mem_br_taken = c[1]; imem_resp = c[2]; dmem_req = c[3]; dmem_resp = c[4];
            #1;
            chk("R7 R8 R9 R10 ctl", act_ctl(), exp_ctl(c[0], c[1], c[2], c[3], c[4]));
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule